// File: doc/BRIEF.md
# Burst flash bus front-end

This block is the device-side bus interface of a NOR-style flash die that serves both asynchronous and synchronous (burst) reads. It watches the host's chip select, read enable, write enable, address-strobe and bus clock pins. From them it produces the address presented to the storage array, the enable for the data output drivers, a latched write address and write data with a one-cycle write pulse, and a WAIT indication with its own drive enable.

All pins are sampled on a fast internal clock `clk`. A rising edge of the address strobe, the bus clock or the write enable is recognised as a sampled low-to-high change. In synchronous mode the start address is taken on whichever comes first: a bus clock rise while the strobe is low, or the strobe's own rise. A programmable latency then keeps WAIT asserted for a number of bus clock rises. After that, each further rise steps the address counter, which wraps at the array size. In asynchronous mode the address flows straight to the array while the strobe is low, and it is held from the strobe's rise onward.

Top module: `burst_flash_frontend`

## Requirements
- R1: In synchronous mode (`syncMode`=1) the address is captured on the first bus clock rise seen while `advN` is low, or on the `advN` rise if no such bus clock rise came first. Only one capture is made per low phase of `advN`.
- R2: In asynchronous mode (`syncMode`=0), with `ceN` low, `arrayAddr` follows `addrIn` in the same cycle while `advN` is low. The address present at the `advN` rise is then held, and later changes on `addrIn` do not reach `arrayAddr`.
- R3: After a synchronous capture with `latency`=L, WAIT stays asserted for the next L bus clock rises and is deasserted once the L-th rise is seen. With L=0 it is deasserted at once.
- R4: Once WAIT is deasserted in a burst, each further bus clock rise increments `arrayAddr` by one, modulo 2^AW (0xFF wraps to 0x00 for AW=8).
- R5: On a rise of `weN` while `ceN` is low, `wrAddr` and `wrData` take `addrIn` and `dataIn`, and `wrStrobe` is high for exactly one `clk` cycle.
- R6: WAIT is asserted throughout asynchronous mode, and whenever `weN` is low.
- R7: `waitPolHigh`=1 drives asserted WAIT as 1 on `waitOut`. `waitPolHigh`=0 drives asserted WAIT as 0.
- R8: `waitEn` is 1 exactly when `ceN` is low, whatever the value of `oeN`.
- R9: `dataOutEn` is 1 only when both `ceN` and `oeN` are low.
- R10: While `ceN` is high no capture is made, and any burst and latency count are cleared. After `ceN` returns low, WAIT stays asserted in synchronous mode and `arrayAddr` stays unchanged until a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast internal sampling clock |
| rstN | input | 1 | active-low reset |
| busClk | input | 1 | host bus clock |
| ceN | input | 1 | chip enable, active low |
| oeN | input | 1 | output enable, active low |
| weN | input | 1 | write enable, active low |
| advN | input | 1 | address strobe, active low |
| addrIn | input | AW | address bus |
| dataIn | input | DW | write data bus |
| syncMode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous |
| waitPolHigh | input | 1 | WAIT asserted level: 1 = high, 0 = low |
| latency | input | LW | first-access latency in bus clock rises |
| arrayAddr | output | AW | address to the array |
| dataOutEn | output | 1 | data output driver enable |
| wrAddr | output | AW | latched write address |
| wrData | output | DW | latched write data |
| wrStrobe | output | 1 | one-cycle write pulse |
| waitOut | output | 1 | WAIT level |
| waitEn | output | 1 | WAIT driver enable |

## Verification
Edges on `busClk`, `advN` and `weN` are recognised at the first `clk` rise after the pin changes. Captured addresses, latency counts, burst steps and the write pulse appear on the outputs just after that same rise. `dataOutEn`, `waitEn` and the asynchronous flow-through path are combinational and settle in the cycle in which the input changes. The bench changes inputs on the falling edge of `clk`. A bus clock pulse spans two falling edges, so that its rise falls between them, and results are read a moment after the falling edge that follows the rise that produced them. Combinational results are read a moment after the input change itself.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  typedef struct packed {
    logic capture;    // take addrIn as burst/async start address
    logic advance;    // step the burst address
    logic flow;       // pass addrIn straight through
    logic wrCapture;  // latch write address/data
  } strobe_t;
endpackage

// File: rtl/bfe_ctrl.sv
module bfe_ctrl #(
  parameter int LW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busClk,
  input  logic            ceN,
  input  logic            weN,
  input  logic            advN,
  input  logic            syncMode,
  input  logic            waitPolHigh,
  input  logic [LW-1:0]   latency,
  output bfe_pkg::strobe_t strb,
  output logic            waitOut,
  output logic            waitEn
);
  logic advPrev, busPrev, wePrev;
  logic latched, burst;
  logic [LW-1:0] cnt;
  logic advRise, advFall, busRise, weRise, latchedEff;
  logic stepOk, countDown, waitActive;

  always_comb begin
    advRise    = advN & ~advPrev;
    advFall    = ~advN & advPrev;
    busRise    = busClk & ~busPrev;
    weRise     = weN & ~wePrev;
    latchedEff = latched & ~advFall;
    strb.capture   = ~ceN & ~latchedEff &
                     (advRise | (syncMode & busRise & ~advN));
    stepOk         = ~ceN & syncMode & burst & busRise & weN & ~strb.capture;
    strb.advance   = stepOk & (cnt == '0);
    countDown      = stepOk & (cnt != '0);
    strb.flow      = ~ceN & ~advN & ~syncMode;
    strb.wrCapture = ~ceN & weRise;
    waitActive     = ~syncMode | ~weN | ~burst | (cnt != '0);
    waitOut        = waitPolHigh ? waitActive : ~waitActive;
    waitEn         = ~ceN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      advPrev <= 1'b1;
      busPrev <= 1'b0;
      wePrev  <= 1'b1;
      latched <= 1'b0;
      burst   <= 1'b0;
      cnt     <= '0;
    end else begin
      advPrev <= advN;
      busPrev <= busClk;
      wePrev  <= weN;
      if (ceN) begin
        latched <= 1'b0;
        burst   <= 1'b0;
        cnt     <= '0;
      end else begin
        if (strb.capture) latched <= 1'b1;
        else if (advFall) latched <= 1'b0;
        if (strb.capture) begin
          burst <= syncMode;
          cnt   <= syncMode ? latency : '0;
        end else if (countDown) begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!burst && cnt == '0)); // R10
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && syncMode) |=> (cnt == $past(latency))); // R3
endmodule

// File: rtl/bfe_datapath.sv
module bfe_datapath #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  bfe_pkg::strobe_t strb,
  input  logic [AW-1:0]    addrIn,
  input  logic [DW-1:0]    dataIn,
  output logic [AW-1:0]    arrayAddr,
  output logic [AW-1:0]    wrAddr,
  output logic [DW-1:0]    wrData,
  output logic             wrStrobe
);
  logic [AW-1:0] addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrStrobe <= 1'b0;
    end else begin
      if (strb.capture)      addrReg <= addrIn;
      else if (strb.advance) addrReg <= addrReg + 1'b1;
      wrStrobe <= strb.wrCapture;
      if (strb.wrCapture) begin
        wrAddr <= addrIn;
        wrData <= dataIn;
      end
    end
  end

  assign arrayAddr = strb.flow ? addrIn : addrReg;

  AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (addrReg == $past(addrIn))); // R1
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.capture) |=> (addrReg == $past(addrReg) + 1'b1)); // R4
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R5
endmodule

// File: rtl/burst_flash_frontend.sv
module burst_flash_frontend #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busClk,
  input  logic          ceN,
  input  logic          oeN,
  input  logic          weN,
  input  logic          advN,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  input  logic          syncMode,
  input  logic          waitPolHigh,
  input  logic [LW-1:0] latency,
  output logic [AW-1:0] arrayAddr,
  output logic          dataOutEn,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic          wrStrobe,
  output logic          waitOut,
  output logic          waitEn
);
  bfe_pkg::strobe_t strb;

  bfe_ctrl #(.LW(LW)) ctrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .ceN(ceN), .weN(weN),
    .advN(advN), .syncMode(syncMode), .waitPolHigh(waitPolHigh),
    .latency(latency), .strb(strb), .waitOut(waitOut), .waitEn(waitEn)
  );

  bfe_datapath #(.AW(AW), .DW(DW)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .dataIn(dataIn),
    .arrayAddr(arrayAddr), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrobe(wrStrobe)
  );

  assign dataOutEn = ~ceN & ~oeN;
endmodule

// File: tb/burst_flash_frontend_test.sv
module burst_flash_frontend_test;
  logic clk = 0, rstN = 0, busClk = 0, ceN = 1, oeN = 1, weN = 1, advN = 1;
  logic [7:0] addrIn = 0;
  logic [15:0] dataIn = 0;
  logic syncMode = 1, waitPolHigh = 1;
  logic [2:0] latency = 0;
  logic [7:0] arrayAddr, wrAddr;
  logic [15:0] wrData;
  logic dataOutEn, wrStrobe, waitOut, waitEn;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_flash_frontend uut (.*);

  typedef struct packed { logic [2:0] lat; logic [7:0] start; logic [3:0] beats; } vec_t;
  localparam vec_t VECS [4] = '{
    '{3'd2, 8'h10, 4'd3}, '{3'd0, 8'h40, 4'd2},
    '{3'd5, 8'h7A, 4'd2}, '{3'd3, 8'hFE, 4'd4}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseBus();
    @(negedge clk) busClk = 1;
    @(negedge clk) busClk = 0;
    #1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    chk(waitEn == 0, "R8 reset", waitEn, 0);
    chk(dataOutEn == 0, "R9 reset", dataOutEn, 0);
    chk(wrStrobe == 0, "R5 reset", wrStrobe, 0);

    // table-driven synchronous bursts, capture on bus clock with ADV low
    foreach (VECS[i]) begin
      @(negedge clk);
      ceN = 0; syncMode = 1; latency = VECS[i].lat; addrIn = VECS[i].start; advN = 0;
      @(negedge clk);
      pulseBus();
      @(negedge clk) begin advN = 1; addrIn = ~VECS[i].start; end
      @(negedge clk); #1;
      chk(arrayAddr == VECS[i].start, "R1 single capture", arrayAddr, VECS[i].start);
      chk(waitOut == (VECS[i].lat != 0), "R3 initial wait", waitOut, VECS[i].lat != 0);
      for (int k = 1; k <= int'(VECS[i].lat); k++) begin
        pulseBus();
        chk(waitOut == (k < int'(VECS[i].lat)), "R3 latency", waitOut, k < int'(VECS[i].lat));
      end
      chk(arrayAddr == VECS[i].start, "R4 first beat", arrayAddr, VECS[i].start);
      for (int b = 1; b < int'(VECS[i].beats); b++) begin
        logic [7:0] e;
        e = VECS[i].start + 8'(b);
        pulseBus();
        chk(arrayAddr == e, "R4 burst step", arrayAddr, e);
      end
    end
    // last burst ended at 0x01 after wrapping from 0xFF

    // R6: write during valid burst asserts wait; R5 write capture
    @(negedge clk) begin weN = 0; addrIn = 8'h5C; dataIn = 16'hBEEF; end
    #1 chk(waitOut == 1, "R6 wait during write", waitOut, 1);
    @(negedge clk) weN = 1;
    @(negedge clk); #1;
    chk(wrStrobe == 1, "R5 strobe", wrStrobe, 1);
    chk(wrAddr == 8'h5C, "R5 addr", wrAddr, 8'h5C);
    chk(wrData == 16'hBEEF, "R5 data", wrData, 16'hBEEF);
    @(negedge clk); #1;
    chk(wrStrobe == 0, "R5 one cycle", wrStrobe, 0);
    chk(waitOut == 0, "R6 wait released", waitOut, 0);

    // R8 / R9
    @(negedge clk) oeN = 1;
    #1 chk(dataOutEn == 0, "R9 oe high", dataOutEn, 0);
    chk(waitEn == 1, "R8 not gated by oe", waitEn, 1);
    @(negedge clk) oeN = 0;
    #1 chk(dataOutEn == 1, "R9 both low", dataOutEn, 1);

    // R10: chip disable clears burst
    @(negedge clk) ceN = 1;
    #1 chk(waitEn == 0, "R8 ce high", waitEn, 0);
    chk(dataOutEn == 0, "R9 ce high", dataOutEn, 0);
    pulseBus();
    @(negedge clk) ceN = 0;
    pulseBus();
    chk(waitOut == 1, "R10 burst cleared", waitOut, 1);
    chk(arrayAddr == 8'h01, "R10 addr held", arrayAddr, 8'h01);

    // R1: capture on ADV rise when no bus clock came first
    @(negedge clk) begin latency = 0; addrIn = 8'h21; advN = 0; end
    @(negedge clk) advN = 1;
    @(negedge clk); #1;
    chk(arrayAddr == 8'h21, "R1 adv rise capture", arrayAddr, 8'h21);
    chk(waitOut == 0, "R3 zero latency", waitOut, 0);

    // R7: polarity low
    @(negedge clk) waitPolHigh = 0;
    #1 chk(waitOut == 1, "R7 deasserted level low-pol", waitOut, 1);
    @(negedge clk) weN = 0;
    #1 chk(waitOut == 0, "R7 asserted level low-pol", waitOut, 0);
    @(negedge clk) begin weN = 1; waitPolHigh = 1; end

    // R2 async flow-through and hold; R6 async wait
    @(negedge clk) begin syncMode = 0; advN = 0; addrIn = 8'h33; end
    #1 chk(arrayAddr == 8'h33, "R2 flow", arrayAddr, 8'h33);
    chk(waitOut == 1, "R6 async wait", waitOut, 1);
    @(negedge clk) addrIn = 8'h44;
    #1 chk(arrayAddr == 8'h44, "R2 flow change", arrayAddr, 8'h44);
    @(negedge clk) advN = 1;
    @(negedge clk) addrIn = 8'h55;
    #1 chk(arrayAddr == 8'h44, "R2 hold", arrayAddr, 8'h44);
    pulseBus();
    chk(arrayAddr == 8'h44, "R2 no bus step", arrayAddr, 8'h44);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule